// File: doc/BRIEF.md
# Output Isolation Latch

This block drives the chip-wide output isolation used for board test. A dedicated request input must stay high for a qualified run of counting-clock cycles. When the run is complete, the block raises a global output-disable that pad logic uses to turn off every output driver, so all outputs float. At the same time it raises a flag that tells the mode-select logic to apply its override values.

The counting clock is either the synthesizer clock or the raw external clock. A select pin picks one, and its value is captured when power-on reset is released. Each clock domain has its own synchronizer and hold counter. Only the domain chosen at reset may engage.

Once engaged, the block stays engaged even after the request drops. Only a new power-on reset clears it.

Top module: `drv_iso_latch`

## Requirements
- R1: While `rst_ni` is low, and right after it is released with `iso_req_i` low, both `out_disable_o` and `mode_force_o` are 0.
- R2: `iso_req_i` passes through a 2-flop synchronizer and needs 10 consecutive high samples on the selected clock. If it is set before rising edge 1 and held, both outputs are 0 after edge 11 and 1 after edge 12.
- R3: A low sample before the count completes clears the count. Two runs of 9 high cycles with a low cycle between them leave the outputs at 0.
- R4: Once engaged, the outputs stay at 1 after `iso_req_i` returns low, for any number of cycles.
- R5: Only power-on reset (`rst_ni` low) returns the outputs to 0.
- R6: With the select captured as 1 (synthesizer), pulses on `clk_ext_i` never engage the block, however long the request is held.
- R7: With the select captured as 0 (external), pulses on `clk_syn_i` never engage the block. `clk_ext_i` then counts exactly as in R2.
- R8: `clk_sel_i` is sampled on the rising edge of `rst_ni`. Later changes to it do not move counting to the other clock.
- R9: `mode_force_o` always equals `out_disable_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_syn_i | input | 1 | Synthesizer clock |
| clk_ext_i | input | 1 | Raw external clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| clk_sel_i | input | 1 | Counting clock select: 1 synthesizer, 0 external; captured at reset release |
| iso_req_i | input | 1 | Isolation request, asynchronous |
| out_disable_o | output | 1 | Global output-driver disable |
| mode_force_o | output | 1 | Force mode-select override values |

## Verification
A counter that is off by one shows up as the outputs rising one selected-clock edge early or late against the edge-12 boundary. A counter that fails to clear shows up as the split 9+9 run engaging. A captured select that is wrong, or that follows the pin after reset, shows up as engagement while only the other clock toggles. A latch that is not sticky shows up within one cycle of the request dropping. The bench stops one clock at a time so that each of these faults appears at the two outputs within a few cycles.

// File: rtl/drv_iso_pkg.sv
package drv_iso_pkg;
  localparam int unsigned HOLD_DEF = 10;
  localparam int unsigned SYNC_DEF = 2;

  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_SYN = 1'b1
  } clk_src_e;
endpackage

// File: rtl/drv_iso_sync.sv
module drv_iso_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/drv_iso_hold.sv
module drv_iso_hold #(
  parameter int unsigned HOLD = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic req_i,
  output logic eng_o
);
  localparam int unsigned CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             eng_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      eng_q <= 1'b0;
    end else if (!en_i || !req_i) begin
      cnt_q <= '0;
    end else if (!eng_q) begin
      if (cnt_q == LAST) eng_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign eng_o = eng_q;

  assert_no_early_engage_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eng_q && cnt_q != LAST) |=> !eng_q);
  assert_low_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (cnt_q == '0));
  assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_q |=> eng_q);
  assert_idle_domain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !eng_q);
  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/drv_iso_latch.sv
module drv_iso_latch
  import drv_iso_pkg::*;
#(
  parameter int unsigned HOLD        = HOLD_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic clk_syn_i,
  input  logic clk_ext_i,
  input  logic rst_ni,
  input  logic clk_sel_i,
  input  logic iso_req_i,
  output logic out_disable_o,
  output logic mode_force_o
);
  clk_src_e   src_q;
  logic [1:0] dom_clk;
  logic [1:0] dom_eng;

  // select captured once, at power-on reset release
  always_ff @(posedge rst_ni) src_q <= clk_src_e'(clk_sel_i);

  assign dom_clk = {clk_syn_i, clk_ext_i};

  for (genvar g = 0; g < 2; g++) begin : g_dom
    logic req_s;
    logic dom_en;
    assign dom_en = (src_q == ((g == 1) ? SRC_SYN : SRC_EXT));

    drv_iso_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (dom_clk[g]),
      .rst_ni(rst_ni),
      .d_i   (iso_req_i),
      .q_o   (req_s)
    );

    drv_iso_hold #(.HOLD(HOLD)) u_hold (
      .clk_i (dom_clk[g]),
      .rst_ni(rst_ni),
      .en_i  (dom_en),
      .req_i (req_s),
      .eng_o (dom_eng[g])
    );
  end

  assign out_disable_o = (src_q == SRC_SYN) ? dom_eng[1] : dom_eng[0];
  assign mode_force_o  = out_disable_o;

  assert_sel_held_ext_R8: assert property (@(posedge clk_ext_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(src_q));
  assert_sel_held_syn_R8: assert property (@(posedge clk_syn_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(src_q));
  assert_sticky_out_R4: assert property (@(posedge clk_ext_i) disable iff (!rst_ni)
    out_disable_o |=> out_disable_o);
endmodule

// File: tb/drv_iso_latch_tb.sv
module drv_iso_latch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EXT_HALF   = 7;

  logic clk_syn = 1'b0, clk_ext = 1'b0;
  logic syn_run = 1'b1, ext_run = 1'b1;
  logic rst_n = 1'b0, clk_sel = 1'b0, iso_req = 1'b0;
  logic out_dis, mode_frc;
  int checks = 0, errs = 0;
  bit done = 1'b0;

  always begin #(CLK_PERIOD/2); if (syn_run) clk_syn = ~clk_syn; end
  always begin #(EXT_HALF);     if (ext_run) clk_ext = ~clk_ext; end

  drv_iso_latch dut_i (
    .clk_syn_i(clk_syn), .clk_ext_i(clk_ext), .rst_ni(rst_n),
    .clk_sel_i(clk_sel), .iso_req_i(iso_req),
    .out_disable_o(out_dis), .mode_force_o(mode_frc)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic cyc(input bit syn, input int n);
    for (int i = 0; i < n; i++) if (syn) @(negedge clk_syn); else @(negedge clk_ext);
  endtask

  task automatic por(input bit mode);
    syn_run = 1'b1; ext_run = 1'b1;
    iso_req = 1'b0; rst_n = 1'b0; clk_sel = mode;
    #(CLK_PERIOD*5 + 3);
    chk("R1 in reset out_disable", out_dis, 1'b0);
    chk("R1 in reset mode_force", mode_frc, 1'b0);
    rst_n = 1'b1;
    cyc(1'b1, 3); cyc(1'b0, 3);
  endtask

  task automatic t_reset_state();
    por(1'b1);
    chk("R1 after release out_disable", out_dis, 1'b0);
    chk("R1 after release mode_force", mode_frc, 1'b0);
  endtask

  task automatic t_exact_hold(input bit syn);
    por(syn);
    cyc(syn, 1); iso_req = 1'b1;
    cyc(syn, 11);
    chk("R2 edge 11 still low", out_dis, 1'b0);
    cyc(syn, 1);
    chk("R2 edge 12 engaged", out_dis, 1'b1);
    chk("R9 flag follows", mode_frc, out_dis);
    iso_req = 1'b0;
    cyc(syn, 25);
    chk("R4 sticky after release", out_dis, 1'b1);
    chk("R9 flag sticky", mode_frc, 1'b1);
    por(syn);
    chk("R5 cleared by power-on reset", out_dis, 1'b0);
  endtask

  task automatic t_short_runs();
    por(1'b1);
    cyc(1'b1, 1);
    iso_req = 1'b1; cyc(1'b1, 9);
    iso_req = 1'b0; cyc(1'b1, 1);
    iso_req = 1'b1; cyc(1'b1, 9);
    iso_req = 1'b0; cyc(1'b1, 6);
    chk("R3 split 9+9 no engage", out_dis, 1'b0);
    chk("R3 split 9+9 flag", mode_frc, 1'b0);
  endtask

  task automatic t_syn_ignores_ext();
    por(1'b1);
    cyc(1'b1, 1); syn_run = 1'b0;
    iso_req = 1'b1;
    cyc(1'b0, 30);
    chk("R6 ext pulses ignored", out_dis, 1'b0);
    @(negedge clk_ext); syn_run = 1'b1;
    cyc(1'b1, 11);
    chk("R6 syn edge 11 low", out_dis, 1'b0);
    cyc(1'b1, 1);
    chk("R6 syn edge 12 engaged", out_dis, 1'b1);
  endtask

  task automatic t_ext_ignores_syn();
    por(1'b0);
    cyc(1'b0, 1); ext_run = 1'b0;
    iso_req = 1'b1;
    cyc(1'b1, 30);
    chk("R7 syn pulses ignored", out_dis, 1'b0);
    @(negedge clk_syn); ext_run = 1'b1;
    cyc(1'b0, 11);
    chk("R7 ext edge 11 low", out_dis, 1'b0);
    cyc(1'b0, 1);
    chk("R7 ext edge 12 engaged", out_dis, 1'b1);
  endtask

  task automatic t_sel_after_reset();
    por(1'b0);
    clk_sel = 1'b1;
    cyc(1'b0, 1); ext_run = 1'b0;
    iso_req = 1'b1;
    cyc(1'b1, 30);
    chk("R8 late select ignored", out_dis, 1'b0);
    @(negedge clk_syn); ext_run = 1'b1;
    cyc(1'b0, 12);
    chk("R8 ext still counts", out_dis, 1'b1);
  endtask

  initial begin
    t_reset_state();
    t_exact_hold(1'b1);
    t_exact_hold(1'b0);
    t_short_runs();
    t_syn_ignores_ext();
    t_ext_ignores_syn();
    t_sel_after_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule